// File: doc/BRIEF.md
# Parameter Word Distributor

The distributor listens to a shared 16-bit parameter bus and steers each control value into the right register of the right signal-generator channel. A separate strobe line marks each bus word. That strobe is not tied to the system clock, so the block brings it into the system clock domain and acts once on each rising edge it finds. Bit 15 of every word decides how the word is used. When bit 15 is 1, the low 15 bits are an address. The address is kept in a latch until the next address word arrives. When bit 15 is 0, the low 15 bits are a data value. That value goes into the parameter register that the held address points to.

Each generator channel gets a bank of parameter registers and one single-cycle update strobe per register. The channel can use the strobe to pick up a new setting at the moment it lands. A data word that cannot be delivered is dropped and raises a sticky error flag. This covers two cases: the held address names a channel or register that does not exist, or no address has been seen since reset.

Top module: `param_distributor`

## Requirements
- R1: While `rst_n` is low and after its release, every parameter register reads 0, every update strobe is 0 and `map_err_o` is 0.
- R2: A word with bit 15 = 1 is an address word: its low 15 bits replace the held address, and it changes no parameter register and raises no update strobe.
- R3: A word with bit 15 = 0 is a data word. When the held address is mapped, its low 15 bits are written to channel `addr[14:11]`, register `addr[3:0]`, and all other registers keep their values. An address is mapped when `addr[10:4]` is zero and `addr[14:11] < NUM_MOD`.
- R4: The held address stays in place across any number of data words, so consecutive data words all land in the same register, and the last one wins.
- R5: Each write raises exactly that register's bit of `upd_o` for exactly one clock cycle. The strobe appears in the same cycle the new value becomes visible, which is the third rising clock edge counting the first edge that samples the bus strobe high.
- R6: One rising edge of `word_stb_i` causes at most one action, however long the strobe stays high.
- R7: A data word whose held address is unmapped changes no register, raises no update strobe and sets `map_err_o`.
- R8: A data word that arrives before any address word since reset changes no register, raises no update strobe and sets `map_err_o`.
- R9: `map_err_o` stays set until reset, and later mapped writes still complete normally.
- R10: `bank_o` holds register (m, r) at bits `[(m*NUM_REG+r)*15 +: 15]`, and `upd_o` bit `m*NUM_REG+r` is its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb_i | input | 1 | Bus word strobe, asynchronous to `clk`; its rising edge marks a word |
| word_i | input | 16 | Bus word; bit 15 set = address, clear = data; stable around the strobe |
| bank_o | output | NUM_MOD*NUM_REG*15 | All parameter registers, flattened |
| upd_o | output | NUM_MOD*NUM_REG | Per-register single-cycle update strobes |
| map_err_o | output | 1 | Sticky flag for dropped data words |

## Verification
The bench targets these corner cases:

- Data words sent before any address. A design that wrote them to register 0 would corrupt channel 0.
- Addresses with a nonzero gap field, or with a channel index of 12 or above. A decoder that ignored those bits would alias them onto real registers.
- A strobe held high for many cycles. A level-sensitive design would write the same register over and over.
- Long runs of data words after one address. A design that cleared the latch after one use would drop every later word.

For every word, the bench checks the whole register image, the exact position and width of the update pulse, and the error flag.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int WORD_W = 16;
  localparam int BODY_W = WORD_W - 1;
  localparam int MOD_W  = 4;
  localparam int REG_W  = 4;
  localparam int GAP_W  = BODY_W - MOD_W - REG_W;

  typedef struct packed {
    logic              is_addr;
    logic [BODY_W-1:0] body;
  } pd_word_t;

  typedef struct packed {
    logic [MOD_W-1:0] mod_idx;
    logic [GAP_W-1:0] gap;
    logic [REG_W-1:0] reg_idx;
  } pd_addr_t;
endpackage

// File: rtl/pd_sync_edge.sv
module pd_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/pd_decode.sv
module pd_decode
  import pd_pkg::*;
#(
  parameter int NUM_MOD = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  pd_word_t          word_i,
  output logic              wr_en_o,
  output logic [MOD_W-1:0]  wr_mod_o,
  output logic [REG_W-1:0]  wr_reg_o,
  output logic [BODY_W-1:0] wr_data_o,
  output logic              err_o
);
  localparam logic [MOD_W:0] MOD_LIMIT = (MOD_W+1)'(NUM_MOD);

  pd_addr_t addr_q, addr_d;
  logic     vld_q, vld_d;
  logic     err_q, err_d;
  logic     addr_en, data_take, mapped, err_set;

  always_comb begin
    addr_en   = take_i &  word_i.is_addr;
    data_take = take_i & ~word_i.is_addr;
    mapped    = vld_q && (addr_q.gap == '0) &&
                ({1'b0, addr_q.mod_idx} < MOD_LIMIT);
    err_set   = data_take & ~mapped;
    addr_d    = pd_addr_t'(word_i.body);
    vld_d     = 1'b1;
    err_d     = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else if (addr_en) begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= err_d;
  end

  assign wr_en_o   = data_take & mapped;
  assign wr_mod_o  = addr_q.mod_idx;
  assign wr_reg_o  = addr_q.reg_idx;
  assign wr_data_o = word_i.body;
  assign err_o     = err_q;
endmodule

// File: rtl/pd_bank.sv
module pd_bank
  import pd_pkg::*;
#(
  parameter int NUM_REG = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_i,
  input  logic [REG_W-1:0]          reg_idx_i,
  input  logic [BODY_W-1:0]         data_i,
  output logic [NUM_REG*BODY_W-1:0] bank_o,
  output logic [NUM_REG-1:0]        upd_o
);
  logic [NUM_REG-1:0] we;
  logic [NUM_REG-1:0] upd_q;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    logic [BODY_W-1:0] val_q, val_d;

    always_comb begin
      we[r] = sel_i && (reg_idx_i == REG_W'(r));
      val_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (we[r]) val_q <= val_d;
    end

    assign bank_o[r*BODY_W +: BODY_W] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= '0;
    else        upd_q <= we;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/param_distributor.sv
module param_distributor
  import pd_pkg::*;
#(
  parameter int NUM_MOD     = 12,
  parameter int NUM_REG     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              word_stb_i,
  input  logic [15:0]                       word_i,
  output logic [NUM_MOD*NUM_REG*BODY_W-1:0] bank_o,
  output logic [NUM_MOD*NUM_REG-1:0]        upd_o,
  output logic                              map_err_o
);
  localparam int MOD_BANK_W = NUM_REG * BODY_W;

  logic              rise;
  logic              wr_en;
  logic [MOD_W-1:0]  wr_mod;
  logic [REG_W-1:0]  wr_reg;
  logic [BODY_W-1:0] wr_data;

  pd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (word_stb_i),
    .rise_o  (rise)
  );

  pd_decode #(.NUM_MOD(NUM_MOD)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (rise),
    .word_i    (pd_word_t'(word_i)),
    .wr_en_o   (wr_en),
    .wr_mod_o  (wr_mod),
    .wr_reg_o  (wr_reg),
    .wr_data_o (wr_data),
    .err_o     (map_err_o)
  );

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic sel;
    assign sel = wr_en && (wr_mod == MOD_W'(m));

    pd_bank #(.NUM_REG(NUM_REG)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel),
      .reg_idx_i (wr_reg),
      .data_i    (wr_data),
      .bank_o    (bank_o[m*MOD_BANK_W +: MOD_BANK_W]),
      .upd_o     (upd_o[m*NUM_REG +: NUM_REG])
    );
  end
endmodule

// File: rtl/param_distributor_chk.sv
module param_distributor_chk #(
  parameter int NUM_MOD = 12,
  parameter int NUM_REG = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_MOD*NUM_REG*15-1:0] bank_o,
  input logic [NUM_MOD*NUM_REG-1:0]    upd_o,
  input logic                          map_err_o
);
  // R5: a word writes at most one register
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o));

  // R5 / R6: an update strobe lasts one cycle and is never repeated back to back
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |=> (upd_o == '0));

  // R3 / R7: the register image changes only alongside an update strobe
  a_r3_quiet_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o == '0) |-> $stable(bank_o));

  // R9: the error flag is sticky
  a_r9_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    map_err_o |=> map_err_o);

  // R7 / R8: a dropped word raises no update strobe
  a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(map_err_o) |-> (upd_o == '0));
endmodule

bind param_distributor param_distributor_chk #(
  .NUM_MOD(NUM_MOD),
  .NUM_REG(NUM_REG)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_o    (bank_o),
  .upd_o     (upd_o),
  .map_err_o (map_err_o)
);

// File: tb/test_param_distributor.sv
module test_param_distributor;
  localparam int NM = 12;
  localparam int NR = 16;
  localparam int NT = NM * NR;

  logic             clk;
  logic             rst_n;
  logic             word_stb_i;
  logic [15:0]      word_i;
  logic [NT*15-1:0] bank_o;
  logic [NT-1:0]    upd_o;
  logic             map_err_o;

  param_distributor #(.NUM_MOD(NM), .NUM_REG(NR)) i_param_distributor (
    .clk(clk), .rst_n(rst_n), .word_stb_i(word_stb_i), .word_i(word_i),
    .bank_o(bank_o), .upd_o(upd_o), .map_err_o(map_err_o)
  );

  int vectors;
  int fails;
  logic [14:0] exp_bank [NT];
  logic [14:0] exp_addr;
  logic        exp_vld;
  logic        exp_err;
  int          pulse_cnt;
  int          pulse_idx;
  int          pulse_width_bad;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic bit addr_mapped(input logic [14:0] a);
    return (a[10:4] == 7'd0) && (int'(a[14:11]) < NM);
  endfunction

  function automatic int addr_slot(input logic [14:0] a);
    return int'(a[14:11]) * NR + int'(a[3:0]);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int bad = 0;
    for (int i = 0; i < NT; i++)
      if (bank_o[i*15 +: 15] != exp_bank[i]) bad++;
    check({req, " mismatched registers"}, bad, 0);
  endtask

  // drive one word with the strobe held hold_cyc cycles, watch strobes
  task automatic send(input logic [15:0] w, input int hold_cyc, input string req);
    int exp_slot = -1;
    bit prev_hi = 0;
    pulse_cnt = 0; pulse_idx = -1; pulse_width_bad = 0;
    if (w[15]) begin
      exp_addr = w[14:0];
      exp_vld  = 1'b1;
    end else if (exp_vld && addr_mapped(exp_addr)) begin
      exp_slot = addr_slot(exp_addr);
      exp_bank[exp_slot] = w[14:0];
    end else begin
      exp_err = 1'b1;
    end
    @(negedge clk);
    word_i = w;
    word_stb_i = 1'b1;
    for (int c = 0; c < hold_cyc + 5; c++) begin
      @(negedge clk);
      if (c == hold_cyc - 1) word_stb_i = 1'b0;
      if (|upd_o) begin
        for (int i = 0; i < NT; i++)
          if (upd_o[i]) begin pulse_cnt++; pulse_idx = i; end
        if (prev_hi) pulse_width_bad++;
        if (c != 2) pulse_width_bad++;
        prev_hi = 1;
      end else prev_hi = 0;
    end
    check({req, " strobe count"}, pulse_cnt, (exp_slot >= 0) ? 1 : 0);
    if (exp_slot >= 0) begin
      check({req, " R10 strobe index"}, pulse_idx, exp_slot);
      check({req, " R5 strobe timing"}, pulse_width_bad, 0);
    end
    check_bank(req);
    check({req, " error flag"}, map_err_o, exp_err);
  endtask

  initial begin
    void'($urandom(32'd7731));
    vectors = 0; fails = 0;
    word_stb_i = 1'b0; word_i = '0; rst_n = 1'b0;
    exp_vld = 0; exp_err = 0; exp_addr = '0;
    for (int i = 0; i < NT; i++) exp_bank[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", upd_o, 0);
    check("R1 error in reset", map_err_o, 0);
    check_bank("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_bank("R1 after release");

    send(16'h1234, 3, "R8 data before address");
    send({1'b1, 4'd2, 7'd0, 4'd5}, 3, "R2 address");
    send(16'h0abc, 3, "R3 write");
    send(16'h0111, 3, "R4 repeat write 1");
    send(16'h7fff, 3, "R4 repeat write 2");
    send({1'b1, 4'd0, 7'd0, 4'd0}, 3, "R2 address slot0");
    send(16'h0001, 20, "R6 long strobe");
    send({1'b1, 4'd11, 7'd0, 4'd15}, 3, "R10 last slot addr");
    send(16'h5555, 3, "R10 last slot write");
    send({1'b1, 4'd12, 7'd0, 4'd3}, 3, "R7 addr module 12");
    send(16'h0777, 3, "R7 unmapped module");
    send({1'b1, 4'd1, 7'h10, 4'd3}, 3, "R7 addr gap");
    send(16'h0666, 3, "R7 unmapped gap");
    send({1'b1, 4'd7, 7'd0, 4'd9}, 3, "R9 addr after error");
    send(16'h2468, 3, "R9 write after error");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      if ($urandom % 5 < 2) begin
        logic [6:0] gap = ($urandom % 8 == 0) ? 7'($urandom) : 7'd0;
        w = {1'b1, 4'($urandom), gap, 4'($urandom)};
        send(w, 1 + $urandom % 4, "R2 random address");
      end else begin
        w = {1'b0, 15'($urandom)};
        send(w, 1 + $urandom % 4, "R3 random data");
      end
    end

    rst_n = 1'b0;
    for (int i = 0; i < NT; i++) exp_bank[i] = '0;
    @(negedge clk);
    check_bank("R1 second reset");
    check("R1 error cleared", map_err_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule